// File: doc/BRIEF.md
# Pipeline Exception Tracker and Flush Controller

This block carries the exception state of an in-order five-stage pipeline (fetch, decode, execute, memory, writeback) alongside each instruction. Every stage register holds the instruction word, the instruction address and a 4-bit cause code, where 0 means no exception. A fetch fault tags an instruction with a fetch cause as it enters the pipe. Decode attaches the encoded cause of a trapping instruction only when no earlier cause is present, so the earliest cause always wins and moves with its instruction.

Side effects are blocked only at the memory stage. While an instruction with a non-zero cause sits there, the memory read, memory write, register write and sync requests are forced off. The memory, execute, decode and fetch stage registers are loaded with bubbles at the next edge, and one cycle later the program counter is redirected to the faulting address plus four. An exception in the execute stage already clears decode and fetch, but it causes no redirect. The ALU, register file, memories, forwarding and handler vectors stay outside the block. The decoder's controls for the instruction in decode arrive on simple input ports, and the gated memory-stage controls leave on output ports.

Top module: `excpt_pipe`

## Requirements
- R1: After reset, every stage holds a bubble (word 0, address 0, cause 0, all enables off). `mem_cause_o`, `redirect_o`, `break_o` and all flush strobes read 0, and `normal_upd_o` reads 1.
- R2: An instruction fetched with `fetch_fault_i` high carries cause `FETCH_CAUSE` (default 4'h1). Without the fault it carries cause 0. Either way the cause appears on `mem_cause_o` three edges after the instruction is fetched.
- R3: Decode replaces the cause with `dec_cause_i` only when `dec_trap_i` is high and the cause is still 0. An existing cause is kept, and `dec_cause_i` has no effect while `dec_trap_i` is low.
- R4: While `mem_cause_o` is non-zero, `mem_rd_o`, `mem_wr_o`, `reg_wr_o` and `sync_o` are 0. Otherwise each equals the decode control captured for that instruction.
- R5: `break_o` is high for exactly the one cycle after the memory stage held cause `BRK_CAUSE` (default 4'hB). It stays low for every other cause.
- R6: While the memory stage holds an exception, `flush_ex_o`, `flush_id_o` and `flush_if_o` are high. After the next edge, no younger instruction reaches the memory stage: the instructions already in execute, decode and fetch, and the one fetched at that edge, become bubbles.
- R7: While the execute stage holds an exception and the memory stage does not, `flush_id_o` and `flush_if_o` are high, `flush_ex_o` is low, and no redirect follows in the next cycle.
- R8: One cycle after the memory stage holds an exception, `redirect_o` pulses high for a single cycle, with `redirect_pc_o` equal to that instruction's address plus 4.
- R9: `normal_upd_o` is low in every cycle in which the execute or memory stage holds an exception, and high otherwise.
- R10: An excepting instruction reaches writeback with `wb_reg_wr_o` low and `wb_cause_o` equal to its cause. A clean instruction keeps its register write enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_word_i | input | 32 | Fetched instruction word |
| fetch_addr_i | input | 32 | Address of the fetched word |
| fetch_fault_i | input | 1 | Fetch access fault for this word |
| dec_trap_i | input | 1 | Instruction in decode raises an exception |
| dec_cause_i | input | 4 | Encoded cause of the trapping instruction |
| dec_rd_i | input | 1 | Decoded memory read for instruction in decode |
| dec_wr_i | input | 1 | Decoded memory write |
| dec_regw_i | input | 1 | Decoded register write |
| dec_sync_i | input | 1 | Decoded cache sync request |
| mem_word_o | output | 32 | Memory-stage instruction word |
| mem_addr_o | output | 32 | Memory-stage instruction address |
| mem_cause_o | output | 4 | Memory-stage cause |
| mem_rd_o | output | 1 | Gated memory read |
| mem_wr_o | output | 1 | Gated memory write |
| reg_wr_o | output | 1 | Gated register write |
| sync_o | output | 1 | Gated sync request |
| wb_addr_o | output | 32 | Writeback-stage address |
| wb_cause_o | output | 4 | Writeback-stage cause |
| wb_reg_wr_o | output | 1 | Writeback register write enable |
| flush_ex_o | output | 1 | Execute stage is cleared at the next edge |
| flush_id_o | output | 1 | Decode stage is cleared at the next edge |
| flush_if_o | output | 1 | Fetch stage is cleared at the next edge |
| normal_upd_o | output | 1 | Normal next-PC and forwarding updates allowed |
| redirect_o | output | 1 | PC redirect pulse |
| redirect_pc_o | output | 32 | Redirect target |
| break_o | output | 1 | Break-reached pulse |

## Verification
The assertions assume that `BRK_CAUSE` and `FETCH_CAUSE` are non-zero and that the inputs are stable around each rising edge. The stimulus therefore uses only non-zero trap codes, together with one deliberate zero-flag case, and drives every input on the falling edge. The redirect and break checks also assume that no reset arrives in the middle of an exception. The bench asserts reset only once, at the start.

// File: rtl/excpt_pipe_pkg.sv
package excpt_pipe_pkg;
  localparam int unsigned XW   = 32;
  localparam int unsigned CW   = 4;
  localparam int unsigned NSTG = 4;
  localparam int unsigned S_IF  = 0;
  localparam int unsigned S_ID  = 1;
  localparam int unsigned S_EX  = 2;
  localparam int unsigned S_MEM = 3;

  typedef logic [CW-1:0] cause_t;
  localparam cause_t        CAUSE_NONE = '0;
  localparam logic [XW-1:0] NOP_WORD   = '0;

  typedef struct packed {
    logic [XW-1:0] word;
    logic [XW-1:0] addr;
    cause_t        cause;
    logic          rd;
    logic          wr;
    logic          regw;
    logic          sync;
  } slot_t;

  function automatic slot_t bubble_slot();
    slot_t s;
    s       = '0;
    s.word  = NOP_WORD;
    s.cause = CAUSE_NONE;
    return s;
  endfunction
endpackage

// File: rtl/excpt_stage_reg.sv
module excpt_stage_reg
  import excpt_pipe_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  kill_i,
  input  slot_t d_i,
  output slot_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= bubble_slot();
    else if (kill_i) q_o <= bubble_slot();
    else             q_o <= d_i;
  end
endmodule

// File: rtl/excpt_decode_merge.sv
module excpt_decode_merge
  import excpt_pipe_pkg::*;
(
  input  slot_t  in_i,
  input  logic   trap_i,
  input  cause_t cause_i,
  input  logic   rd_i,
  input  logic   wr_i,
  input  logic   regw_i,
  input  logic   sync_i,
  output slot_t  out_o
);
  always_comb begin
    out_o      = in_i;
    out_o.rd   = rd_i;
    out_o.wr   = wr_i;
    out_o.regw = regw_i;
    out_o.sync = sync_i;
    // earliest cause wins
    if (trap_i && (in_i.cause == CAUSE_NONE)) out_o.cause = cause_i;
  end
endmodule

// File: rtl/excpt_mem_gate.sv
module excpt_mem_gate
  import excpt_pipe_pkg::*;
(
  input  slot_t m_i,
  output logic  exc_o,
  output logic  rd_o,
  output logic  wr_o,
  output logic  regw_o,
  output logic  sync_o
);
  always_comb begin
    exc_o  = (m_i.cause != CAUSE_NONE);
    rd_o   = m_i.rd   & ~exc_o;
    wr_o   = m_i.wr   & ~exc_o;
    regw_o = m_i.regw & ~exc_o;
    sync_o = m_i.sync & ~exc_o;
  end
endmodule

// File: rtl/excpt_redirect.sv
module excpt_redirect
  import excpt_pipe_pkg::*;
#(
  parameter cause_t BRK_CAUSE = 4'hB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          exc_i,
  input  cause_t        cause_i,
  input  logic [XW-1:0] addr_i,
  output logic          redirect_o,
  output logic [XW-1:0] pc_o,
  output logic          brk_o
);
  localparam logic [XW-1:0] STEP = XW'(4);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      pc_o       <= '0;
      brk_o      <= 1'b0;
    end else begin
      redirect_o <= exc_i;
      brk_o      <= exc_i && (cause_i == BRK_CAUSE);
      if (exc_i) pc_o <= addr_i + STEP;
    end
  end
endmodule

// File: rtl/excpt_pipe.sv
module excpt_pipe
  import excpt_pipe_pkg::*;
#(
  parameter cause_t BRK_CAUSE   = 4'hB,
  parameter cause_t FETCH_CAUSE = 4'h1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [XW-1:0] fetch_word_i,
  input  logic [XW-1:0] fetch_addr_i,
  input  logic          fetch_fault_i,
  input  logic          dec_trap_i,
  input  logic [CW-1:0] dec_cause_i,
  input  logic          dec_rd_i,
  input  logic          dec_wr_i,
  input  logic          dec_regw_i,
  input  logic          dec_sync_i,
  output logic [XW-1:0] mem_word_o,
  output logic [XW-1:0] mem_addr_o,
  output logic [CW-1:0] mem_cause_o,
  output logic          mem_rd_o,
  output logic          mem_wr_o,
  output logic          reg_wr_o,
  output logic          sync_o,
  output logic [XW-1:0] wb_addr_o,
  output logic [CW-1:0] wb_cause_o,
  output logic          wb_reg_wr_o,
  output logic          flush_ex_o,
  output logic          flush_id_o,
  output logic          flush_if_o,
  output logic          normal_upd_o,
  output logic          redirect_o,
  output logic [XW-1:0] redirect_pc_o,
  output logic          break_o
);
  slot_t            stg_d [NSTG];
  slot_t            stg_q [NSTG];
  logic [NSTG-1:0]  kill;
  slot_t            if_d;
  slot_t            id_d;
  logic             mem_exc;
  logic             ex_exc;

  // fetch entry
  always_comb begin
    if_d       = bubble_slot();
    if_d.word  = fetch_word_i;
    if_d.addr  = fetch_addr_i;
    if_d.cause = fetch_fault_i ? FETCH_CAUSE : CAUSE_NONE;
  end

  excpt_decode_merge u_dec (
    .in_i    (stg_q[S_IF]),
    .trap_i  (dec_trap_i),
    .cause_i (dec_cause_i),
    .rd_i    (dec_rd_i),
    .wr_i    (dec_wr_i),
    .regw_i  (dec_regw_i),
    .sync_i  (dec_sync_i),
    .out_o   (id_d)
  );

  assign stg_d[S_IF]  = if_d;
  assign stg_d[S_ID]  = id_d;
  assign stg_d[S_EX]  = stg_q[S_ID];
  assign stg_d[S_MEM] = stg_q[S_EX];

  assign ex_exc = (stg_q[S_EX].cause != CAUSE_NONE);

  // memory-stage fault clears everything younger; execute fault clears decode/fetch
  assign kill[S_MEM] = mem_exc;
  assign kill[S_EX]  = mem_exc | ex_exc;
  assign kill[S_ID]  = mem_exc | ex_exc;
  assign kill[S_IF]  = mem_exc | ex_exc;

  for (genvar g = 0; g < NSTG; g++) begin : g_stage
    excpt_stage_reg u_reg (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .kill_i (kill[g]),
      .d_i    (stg_d[g]),
      .q_o    (stg_q[g])
    );
  end

  excpt_mem_gate u_gate (
    .m_i    (stg_q[S_MEM]),
    .exc_o  (mem_exc),
    .rd_o   (mem_rd_o),
    .wr_o   (mem_wr_o),
    .regw_o (reg_wr_o),
    .sync_o (sync_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_addr_o   <= '0;
      wb_cause_o  <= CAUSE_NONE;
      wb_reg_wr_o <= 1'b0;
    end else begin
      wb_addr_o   <= stg_q[S_MEM].addr;
      wb_cause_o  <= stg_q[S_MEM].cause;
      wb_reg_wr_o <= reg_wr_o;
    end
  end

  excpt_redirect #(.BRK_CAUSE(BRK_CAUSE)) u_redir (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .exc_i      (mem_exc),
    .cause_i    (stg_q[S_MEM].cause),
    .addr_i     (stg_q[S_MEM].addr),
    .redirect_o (redirect_o),
    .pc_o       (redirect_pc_o),
    .brk_o      (break_o)
  );

  assign mem_word_o   = stg_q[S_MEM].word;
  assign mem_addr_o   = stg_q[S_MEM].addr;
  assign mem_cause_o  = stg_q[S_MEM].cause;
  assign flush_ex_o   = mem_exc;
  assign flush_id_o   = mem_exc | ex_exc;
  assign flush_if_o   = mem_exc | ex_exc;
  assign normal_upd_o = ~(mem_exc | ex_exc);
endmodule

// File: rtl/excpt_pipe_chk.sv
module excpt_pipe_chk
  import excpt_pipe_pkg::*;
#(
  parameter cause_t BRK_CAUSE = 4'hB
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [XW-1:0] mem_addr_o,
  input logic [CW-1:0] mem_cause_o,
  input logic          mem_rd_o,
  input logic          mem_wr_o,
  input logic          reg_wr_o,
  input logic          sync_o,
  input logic          flush_ex_o,
  input logic          flush_id_o,
  input logic          flush_if_o,
  input logic          normal_upd_o,
  input logic          redirect_o,
  input logic [XW-1:0] redirect_pc_o,
  input logic          break_o
);
  // R4
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cause_o != CAUSE_NONE) |-> !(mem_rd_o || mem_wr_o || reg_wr_o || sync_o));

  // R5
  break_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cause_o == BRK_CAUSE) |=> break_o);

  // R5
  break_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cause_o != BRK_CAUSE) |=> !break_o);

  // R6
  mem_drain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cause_o != CAUSE_NONE) |=> (mem_cause_o == CAUSE_NONE) && (mem_addr_o == '0));

  // R7
  ex_no_redir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_id_o && !flush_ex_o) |=> !redirect_o);

  // R8
  redir_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_cause_o != CAUSE_NONE) |=> redirect_o && (redirect_pc_o == $past(mem_addr_o) + XW'(4)));

  // R8
  redir_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);

  // R9
  hold_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_if_o || flush_id_o) |-> !normal_upd_o);
endmodule

bind excpt_pipe excpt_pipe_chk #(.BRK_CAUSE(BRK_CAUSE)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .mem_addr_o    (mem_addr_o),
  .mem_cause_o   (mem_cause_o),
  .mem_rd_o      (mem_rd_o),
  .mem_wr_o      (mem_wr_o),
  .reg_wr_o      (reg_wr_o),
  .sync_o        (sync_o),
  .flush_ex_o    (flush_ex_o),
  .flush_id_o    (flush_id_o),
  .flush_if_o    (flush_if_o),
  .normal_upd_o  (normal_upd_o),
  .redirect_o    (redirect_o),
  .redirect_pc_o (redirect_pc_o),
  .break_o       (break_o)
);

// File: tb/excpt_pipe_test.sv
module excpt_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] BRK = 4'hB;
  localparam logic [3:0] FCS = 4'h1;

  typedef struct packed {
    logic       flt;
    logic       trp;
    logic [3:0] dc;
    logic       rd;
    logic       wr;
    logic       rw;
    logic       sy;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0},
    '{1'b0, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{1'b0, 1'b1, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0},
    '{1'b0, 1'b1, 4'hB, 1'b1, 1'b0, 1'b0, 1'b0},
    '{1'b1, 1'b0, 4'h0, 1'b1, 1'b0, 1'b1, 1'b0},
    '{1'b1, 1'b1, 4'h8, 1'b0, 1'b1, 1'b0, 1'b1},
    '{1'b0, 1'b0, 4'h5, 1'b1, 1'b1, 1'b1, 1'b0}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] fetch_word_i = '0, fetch_addr_i = '0;
  logic        fetch_fault_i = 1'b0;
  logic        dec_trap_i = 1'b0;
  logic [3:0]  dec_cause_i = '0;
  logic        dec_rd_i = 1'b0, dec_wr_i = 1'b0, dec_regw_i = 1'b0, dec_sync_i = 1'b0;
  logic [31:0] mem_word_o, mem_addr_o, wb_addr_o, redirect_pc_o;
  logic [3:0]  mem_cause_o, wb_cause_o;
  logic        mem_rd_o, mem_wr_o, reg_wr_o, sync_o, wb_reg_wr_o;
  logic        flush_ex_o, flush_id_o, flush_if_o, normal_upd_o, redirect_o, break_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  excpt_pipe uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic set_dec(input logic trp, input logic [3:0] dc, input logic rd,
                         input logic wr, input logic rw, input logic sy);
    dec_trap_i = trp; dec_cause_i = dc; dec_rd_i = rd; dec_wr_i = wr;
    dec_regw_i = rw; dec_sync_i = sy;
  endtask

  task automatic fetch(input logic [31:0] a, input logic flt);
    fetch_addr_i = a; fetch_word_i = a ^ 32'hA5A5_0000; fetch_fault_i = flt;
  endtask

  initial begin
    repeat (5000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 mem_cause", 32'(mem_cause_o), 0);
    chk("R1 mem_addr", mem_addr_o, 0);
    chk("R1 redirect", 32'(redirect_o), 0);
    chk("R1 break", 32'(break_o), 0);
    chk("R1 flush", 32'({flush_ex_o, flush_id_o, flush_if_o}), 0);
    chk("R1 normal_upd", 32'(normal_upd_o), 1);

    // table walk
    for (int i = 0; i < 8; i++) begin
      logic [31:0] a;
      logic [3:0]  ec;
      logic        ex;
      a  = 32'h1000 + 32'(i) * 32'h40;
      ec = VECS[i].flt ? FCS : (VECS[i].trp ? VECS[i].dc : 4'h0);
      ex = (ec != 4'h0);
      fetch(a, VECS[i].flt);
      set_dec(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk_i);
      fetch(a + 32'd4, 1'b0);
      set_dec(VECS[i].trp, VECS[i].dc, VECS[i].rd, VECS[i].wr, VECS[i].rw, VECS[i].sy);
      @(negedge clk_i);
      set_dec(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
      @(negedge clk_i);
      // instruction in execute
      chk("R7 flush_id", 32'(flush_id_o), 32'(ex));
      chk("R7 flush_ex", 32'(flush_ex_o), 0);
      chk("R9 normal_upd", 32'(normal_upd_o), 32'(!ex));
      @(negedge clk_i);
      // instruction in memory
      chk("R2/R3 mem_cause", 32'(mem_cause_o), 32'(ec));
      chk("R4 enables", 32'({mem_rd_o, mem_wr_o, reg_wr_o, sync_o}),
          ex ? 0 : 32'({VECS[i].rd, VECS[i].wr, VECS[i].rw, VECS[i].sy}));
      chk("R6 flush_ex", 32'(flush_ex_o), 32'(ex));
      chk("R7 no redirect yet", 32'(redirect_o), 0);
      @(negedge clk_i);
      chk("R8 redirect", 32'(redirect_o), 32'(ex));
      if (ex) chk("R8 target", redirect_pc_o, a + 32'd4);
      chk("R5 break", 32'(break_o), 32'(ec == BRK));
      chk("R10 wb_cause", 32'(wb_cause_o), 32'(ec));
      chk("R10 wb_regw", 32'(wb_reg_wr_o), 32'(VECS[i].rw && !ex));
      chk("R6 younger killed", mem_addr_o, ex ? 0 : a + 32'd4);
      @(negedge clk_i);
      chk("R8 single pulse", 32'(redirect_o), 0);
      chk("R5 single pulse", 32'(break_o), 0);
      repeat (3) @(negedge clk_i);
    end

    // back-to-back: older decode trap, younger trap and fetch fault must vanish
    fetch(32'h400, 1'b0);                       // A
    @(negedge clk_i);
    fetch(32'h404, 1'b0);                       // B
    set_dec(1'b1, 4'h8, 1'b0, 1'b0, 1'b1, 1'b0); // A traps
    @(negedge clk_i);
    fetch(32'h500, 1'b1);                       // C with fetch fault
    set_dec(1'b1, 4'h9, 1'b0, 1'b1, 1'b0, 1'b0); // B traps
    @(negedge clk_i);
    set_dec(1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    fetch(32'h500, 1'b0);
    chk("R7 ex flush back2back", 32'({flush_ex_o, flush_id_o, flush_if_o}), 32'b011);
    @(negedge clk_i);
    chk("R3 older wins b2b", 32'(mem_cause_o), 8);
    chk("R6 all flush b2b", 32'({flush_ex_o, flush_id_o, flush_if_o}), 32'b111);
    @(negedge clk_i);
    fetch(32'h404, 1'b0);                       // D, resumed fetch
    chk("R8 b2b target", redirect_pc_o, 32'h404);
    chk("R6 b2b mem bubble 1", 32'(mem_cause_o), 0);
    @(negedge clk_i);
    fetch(32'h408, 1'b0);
    chk("R8 b2b single", 32'(redirect_o), 0);
    chk("R6 b2b mem bubble 2", mem_addr_o, 0);
    @(negedge clk_i);
    chk("R6 b2b mem bubble 3", mem_addr_o, 0);
    chk("R6 b2b no cause", 32'(mem_cause_o), 0);
    @(negedge clk_i);
    chk("R6 b2b mem bubble 4", mem_addr_o, 0);
    chk("R9 b2b resumed", 32'(normal_upd_o), 1);
    @(negedge clk_i);
    chk("R2 resumed clean", mem_addr_o, 32'h404);
    chk("R2 resumed cause", 32'(mem_cause_o), 0);
    chk("R8 no second redirect", 32'(redirect_o), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule